// File: doc/BRIEF.md
# Multi-Mode Configurable Lookup Cell

This block is a six-input lookup cell whose single 64-bit storage array can be used in four ways, chosen by a two-bit mode input. It can act as a combinational function, where the six select inputs pick one stored truth-table bit. It can act as two five-input functions that share the five low select inputs. It can act as a 64x1 RAM with a synchronous write and an asynchronous read. It can also act as a 32-stage shift register whose stage is chosen by an address. No flip-flops outside the array are involved in any of these modes.

The contents are loaded over a serial configuration port, one bit per clock, with the most significant table entry sent first. A change of mode never disturbs what is stored. A table written as RAM, or filled by shifting, can therefore be read back later as a logic function. The cascade output always shows the last shift stage, so that several cells can be chained into a longer delay line.

Top module: `cfg_lut_cell`

## Requirements
- R1: After reset every table entry is 0, so `lut_out`, `lut_lo` and `cascade_out` are 0 for every select value and mode.
- R2: While `cfg_en` is high, each rising clock edge shifts `cfg_bit` into entry 0 and moves every entry k up to entry k+1. After 64 such edges the first bit sent sits in entry 63.
- R3: In mode 2'b00 (logic), `lut_out` equals entry `sel` in the same cycle, with no clock edge needed.
- R4: In mode 2'b01 (split), `lut_out` equals entry 32+`sel[4:0]` and `sel[5]` has no effect. In every mode `lut_lo` equals entry `sel[4:0]` (lower half).
- R5: In mode 2'b10 (RAM), a rising edge with `we` high writes `din` into entry `sel`. `lut_out` reads entry `sel` combinationally.
- R6: In mode 2'b11 (shift), a rising edge with `we` high moves `din` into entry 0 and each entry k (k < 31) into entry k+1. `lut_out` shows entry `sel[4:0]`, and entries 32 to 63 do not change.
- R7: `cascade_out` equals entry 31 in every mode.
- R8: In logic and split modes, `we` and `din` do not change the stored table.
- R9: Changing `mode` with `we` and `cfg_en` low does not alter any stored entry.
- R10: If `cfg_en` is high in the same cycle as an enabled RAM write or shift, only the configuration shift takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset, clears the table |
| cfg_en | input | 1 | Serial configuration shift enable |
| cfg_bit | input | 1 | Serial configuration data, entry 63 first |
| mode | input | 2 | 00 logic, 01 split, 10 RAM, 11 shift |
| sel | input | 6 | Function inputs, RAM address or stage select |
| we | input | 1 | Write enable in RAM mode, shift enable in shift mode |
| din | input | 1 | RAM write data or shift input |
| lut_out | output | 1 | Main lookup output |
| lut_lo | output | 1 | Lower-half five-input output |
| cascade_out | output | 1 | Shift stage 31 |

## Verification
The configuration shift and a user write or shift can both want the array in one clock. The bench creates this by raising `cfg_en` together with `we`, first in RAM mode with a `din` that differs from the bit being loaded, and then in shift mode. It judges the result by reading back all 64 entries through the logic-mode output and comparing them against a model where only the configuration shift happened. Writes in the split and logic modes, and plain mode changes, are checked the same way, by a full readback afterwards.

// File: rtl/cfg_lut_pkg.sv
package cfg_lut_pkg;
   typedef enum logic [1:0] {
      MODE_LOGIC = 2'b00,
      MODE_SPLIT = 2'b01,
      MODE_RAM   = 2'b10,
      MODE_SHIFT = 2'b11
   } lut_mode_t;
endpackage

// File: rtl/cfg_lut_store.sv
module cfg_lut_store
   import cfg_lut_pkg::*;
#(
   parameter int AW      = 6,
   parameter int DEPTH   = 1 << AW,
   parameter int SHIFT_N = DEPTH / 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_en,
   input  logic             cfg_bit,
   input  lut_mode_t        mode,
   input  logic             we,
   input  logic [AW-1:0]    addr,
   input  logic             din,
   output logic [DEPTH-1:0] tbl
);
   if (DEPTH != (1 << AW)) begin : g_bad_depth
      $error("cfg_lut_store: DEPTH must equal 2**AW");
   end
   if (SHIFT_N < 2 || SHIFT_N > DEPTH) begin : g_bad_shift
      $error("cfg_lut_store: SHIFT_N out of range");
   end

   logic user_wr;
   assign user_wr = we && (mode == MODE_RAM || mode == MODE_SHIFT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tbl <= '0;
      end else if (cfg_en) begin
         tbl <= {tbl[DEPTH-2:0], cfg_bit};
      end else if (we) begin
         case (mode)
            MODE_RAM:   tbl[addr] <= din;
            MODE_SHIFT: tbl[SHIFT_N-1:0] <= {tbl[SHIFT_N-2:0], din};
            default:    ;
         endcase
      end
   end

   AST_CFG_ENTRY0: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_en |=> tbl[0] == $past(cfg_bit)); // R2
   AST_CFG_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_en && user_wr) |=> tbl[DEPTH-1] == $past(tbl[DEPTH-2])); // R10
   AST_RAM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_en && we && mode == MODE_RAM) |=> tbl[$past(addr)] == $past(din)); // R5
   AST_UPPER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_en && mode == MODE_SHIFT) |=> $stable(tbl[DEPTH-1:SHIFT_N])); // R6
   AST_NO_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_en && !user_wr) |=> $stable(tbl)); // R8 R9
endmodule

// File: rtl/cfg_lut_rdmux.sv
module cfg_lut_rdmux #(
   parameter int AW = 6,
   parameter int N  = 1 << AW
) (
   input  logic [N-1:0]  data,
   input  logic [AW-1:0] sel,
   output logic          y
);
   if (N > (1 << AW)) begin : g_bad_n
      $error("cfg_lut_rdmux: N exceeds address range");
   end

   if (N == (1 << AW)) begin : g_full
      assign y = data[sel];
   end else begin : g_partial
      assign y = (int'(sel) < N) ? data[sel] : 1'b0;
   end
endmodule

// File: rtl/cfg_lut_cell.sv
module cfg_lut_cell
   import cfg_lut_pkg::*;
#(
   parameter int K        = 6,
   parameter bit SPLIT_EN = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cfg_en,
   input  logic         cfg_bit,
   input  logic [1:0]   mode,
   input  logic [K-1:0] sel,
   input  logic         we,
   input  logic         din,
   output logic         lut_out,
   output logic         lut_lo,
   output logic         cascade_out
);
   localparam int DEPTH   = 1 << K;
   localparam int SHIFT_N = DEPTH / 2;
   localparam int HW      = K - 1;

   if (K < 2 || K > 8) begin : g_bad_k
      $error("cfg_lut_cell: K must be between 2 and 8");
   end

   lut_mode_t        mode_q;
   logic [DEPTH-1:0] tbl;
   logic [K-1:0]     main_addr;

   assign mode_q = lut_mode_t'(mode);

   cfg_lut_store #(.AW(K), .DEPTH(DEPTH), .SHIFT_N(SHIFT_N)) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .cfg_en (cfg_en),
      .cfg_bit(cfg_bit),
      .mode   (mode_q),
      .we     (we),
      .addr   (sel),
      .din    (din),
      .tbl    (tbl)
   );

   always_comb begin
      case (mode_q)
         MODE_SPLIT: main_addr = SPLIT_EN ? {1'b1, sel[HW-1:0]} : sel;
         MODE_SHIFT: main_addr = {1'b0, sel[HW-1:0]};
         default:    main_addr = sel;
      endcase
   end

   cfg_lut_rdmux #(.AW(K), .N(DEPTH)) u_main_mux (
      .data(tbl),
      .sel (main_addr),
      .y   (lut_out)
   );

   if (SPLIT_EN) begin : g_split
      cfg_lut_rdmux #(.AW(HW), .N(SHIFT_N)) u_lo_mux (
         .data(tbl[SHIFT_N-1:0]),
         .sel (sel[HW-1:0]),
         .y   (lut_lo)
      );
   end else begin : g_nosplit
      assign lut_lo = 1'b0;
   end

   assign cascade_out = tbl[SHIFT_N-1];

   AST_CASCADE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_en && we && mode_q == MODE_SHIFT) |=> cascade_out == $past(tbl[SHIFT_N-2])); // R7
   AST_SPLIT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_SPLIT && SPLIT_EN) |-> lut_out == tbl[SHIFT_N + int'(sel[HW-1:0])]); // R4
endmodule

// File: tb/cfg_lut_cell_test.sv
`timescale 1ns/1ps
module cfg_lut_cell_test;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       cfg_en, cfg_bit, we, din;
   logic [1:0] mode;
   logic [5:0] sel;
   logic       lut_out, lut_lo, cascade_out;

   logic [63:0] m;
   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   cfg_lut_cell uut (
      .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_bit(cfg_bit),
      .mode(mode), .sel(sel), .we(we), .din(din),
      .lut_out(lut_out), .lut_lo(lut_lo), .cascade_out(cascade_out)
   );

   task automatic chk(input string req, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%b expected=%b (mode=%b sel=%0d)", req, act, exp, mode, sel);
      end
   endtask

   task automatic readback_all(input string req);
      mode = 2'b00;
      for (int a = 0; a < 64; a++) begin
         sel = 6'(a);
         #1;
         chk(req, lut_out, m[a]);
      end
   endtask

   task automatic t_reset;
      rst_n = 1'b0; cfg_en = 1'b0; cfg_bit = 1'b0; we = 1'b0; din = 1'b0;
      mode = 2'b00; sel = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      m = '0;
      for (int md = 0; md < 4; md++) begin
         mode = 2'(md);
         for (int a = 0; a < 64; a += 7) begin
            sel = 6'(a);
            #1;
            chk("R1 lut_out", lut_out, 1'b0);
            chk("R1 lut_lo", lut_lo, 1'b0);
            chk("R1 cascade_out", cascade_out, 1'b0);
         end
      end
   endtask

   task automatic t_load(input logic [63:0] pat);
      @(negedge clk);
      for (int i = 63; i >= 0; i--) begin
         cfg_en = 1'b1; cfg_bit = pat[i];
         @(negedge clk);
      end
      cfg_en = 1'b0;
      m = pat;
      readback_all("R2 R3 load/logic");
   endtask

   task automatic t_split;
      mode = 2'b01;
      for (int a = 0; a < 32; a++) begin
         for (int h = 0; h < 2; h++) begin
            sel = {1'(h), 5'(a)};
            #1;
            chk("R4 split high", lut_out, m[32 + a]);
            chk("R4 split low", lut_lo, m[a]);
         end
      end
   endtask

   task automatic t_we_ignored;
      for (int md = 0; md < 2; md++) begin
         @(negedge clk);
         mode = 2'(md);
         for (int a = 3; a < 64; a += 11) begin
            sel = 6'(a); we = 1'b1; din = ~m[a];
            @(negedge clk);
         end
         we = 1'b0;
      end
      readback_all("R8 we ignored");
   endtask

   task automatic t_ram;
      @(negedge clk);
      mode = 2'b10;
      for (int a = 0; a < 64; a += 5) begin
         sel = 6'(a); din = ~m[a]; we = 1'b1;
         @(negedge clk);
         we = 1'b0;
         m[a] = din;
         #1;
         chk("R5 ram read", lut_out, m[a]);
      end
      readback_all("R5 ram table");
   endtask

   task automatic t_mode_change;
      for (int md = 0; md < 4; md++) begin
         mode = 2'(3 - md);
         @(negedge clk);
      end
      readback_all("R9 mode change");
   endtask

   task automatic t_shift;
      logic [39:0] seq = 40'h9C_3A5E_71B2;
      @(negedge clk);
      mode = 2'b11;
      for (int i = 0; i < 40; i++) begin
         din = seq[i]; we = 1'b1;
         @(negedge clk);
         we = 1'b0;
         m[31:0] = {m[30:0], seq[i]};
         #1;
         chk("R7 cascade shift", cascade_out, m[31]);
         sel = 6'({1'(i % 2), 5'((i * 13) % 32)});
         #1;
         chk("R6 stage select", lut_out, m[(i * 13) % 32]);
      end
      readback_all("R6 shift table");
      #1;
      chk("R7 cascade logic", cascade_out, m[31]);
   endtask

   task automatic t_collide;
      @(negedge clk);
      mode = 2'b10; sel = 6'd40;
      cfg_en = 1'b1; cfg_bit = 1'b1; we = 1'b1; din = 1'b0;
      @(negedge clk);
      m = {m[62:0], 1'b1};
      mode = 2'b11; sel = 6'd5;
      cfg_bit = 1'b0; din = 1'b1;
      @(negedge clk);
      m = {m[62:0], 1'b0};
      cfg_en = 1'b0; we = 1'b0;
      readback_all("R10 cfg priority");
   endtask

   initial begin
      t_reset();
      t_load(64'hA5C3_0F96_1E78_D24B);
      t_split();
      t_we_ignored();
      t_ram();
      t_mode_change();
      t_shift();
      t_collide();
      t_load(64'h0123_4567_89AB_CDEF);
      t_split();
      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      #(8 * 150000);
      if (!done) begin
         done = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule